// File: doc/BRIEF.md
# Backup-Mode Entry Sequencer

This block runs on the slow clock and carries the device from normal operation into backup mode when software asks for it. Software makes a register write. The write strobe comes with a regulator-off command bit. The block resynchronizes the command, detects its leading edge and then runs a fixed chain of steps that cannot be stopped. First it asserts the system reset. Then it halts the processor and the peripherals. Last, it switches off the core regulator and pulls the active-low shutdown pin low, both in the same cycle.

A separate mode bit chooses whether the internal core regulator is enabled. It is used when the core is powered from an external supply. The mode bit passes through the same resynchronizer as the command. A busy output is high while the chain is running. Only a backup reset (`rst_ni`) brings the block back to idle.

Top module: `bkup_seq_top`

## Requirements
- R1: While `rst_ni` is low and after it is released, the outputs are idle. `sys_rst_o`=0, `core_stop_o`=0, `busy_o`=0, `shdn_no`=1, and `core_reg_en_o`=1 (the mode synchronizer resets to "regulator enabled").
- R2: A write with `wr_strobe_i`=1 and `wr_off_i`=1, first sampled at clock edge k, raises `sys_rst_o` after edge k+SYNC_STAGES (default 2). The command has no earlier visible effect.
- R3: `core_stop_o` rises STOP_DLY edges after `sys_rst_o` rises (default 1). It never rises before `sys_rst_o`.
- R4: `core_reg_en_o` and `shdn_no` both go low OFF_DLY edges after `core_stop_o` rises (default 1), in the same cycle.
- R5: `busy_o` is high exactly from the cycle `sys_rst_o` rises up to, but not including, the cycle `shdn_no` falls.
- R6: A strobe with `wr_off_i`=0 has no effect on any output.
- R7: A strobe held high for several cycles starts exactly one sequence. Once started, the sequence cannot be aborted. Every later write is ignored, and the outputs hold their final values (`sys_rst_o`=1, `core_stop_o`=1, `shdn_no`=0, `core_reg_en_o`=0, `busy_o`=0) until `rst_ni` is asserted.
- R8: With the block idle, `reg_dis_i`=1 drives `core_reg_en_o` to 0 and `reg_dis_i`=0 drives it to 1. A change sampled at edge k appears after edge k+SYNC_STAGES-1 (after the second edge, by default).
- R9: Asserting `rst_ni` from any step returns the block to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock |
| rst_ni | input | 1 | Backup reset, asynchronous, active low |
| wr_strobe_i | input | 1 | Control-register write strobe |
| wr_off_i | input | 1 | Regulator-off command bit of the write |
| reg_dis_i | input | 1 | Mode bit: 1 disables the internal core regulator |
| sys_rst_o | output | 1 | System reset, active high |
| core_stop_o | output | 1 | Stops processor and peripherals |
| core_reg_en_o | output | 1 | Core regulator enable |
| shdn_no | output | 1 | Shutdown pin, active low |
| busy_o | output | 1 | Sequence in progress |

## Verification
Edge k is the first edge that samples the command. After it, the outputs are due at these edges:
- `sys_rst_o` at k+SYNC_STAGES;
- `core_stop_o` STOP_DLY edges later;
- `shdn_no` and `core_reg_en_o` OFF_DLY edges after that;
- a mode change at k+SYNC_STAGES-1.

The bench drives inputs on the falling edge. It samples one time unit after every rising edge and compares each output against these offsets, computed from the parameters. It overrides the delays to 2 and 3 so that the steps are distinct. It sweeps strobe widths and both mode values, and it injects writes during the sequence and after it has finished to show that they are ignored.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RST  = 2'd1,
    ST_STOP = 2'd2,
    ST_OFF  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bkup_sync.sv
module bkup_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[N-1];
endmodule

// File: rtl/bkup_edge.sv
module bkup_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;

  a_r7_single_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/bkup_fsm.sv
module bkup_fsm
  import bkup_pkg::*;
#(
  parameter int STOP_DLY = 1,
  parameter int OFF_DLY  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reg_dis_i,
  output logic sys_rst_o,
  output logic core_stop_o,
  output logic core_reg_en_o,
  output logic shdn_no,
  output logic busy_o
);
  localparam int MAXD = (STOP_DLY > OFF_DLY) ? STOP_DLY : OFF_DLY;
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_DLY - 1);
  localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_DLY - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST;
        cnt_d   = '0;
      end
      ST_RST: begin
        if (cnt_q == STOP_LAST) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP: begin
        if (cnt_q == OFF_LAST) begin
          state_d = ST_OFF;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_OFF: ; // terminal until backup reset
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sys_rst_o     = (state_q != ST_IDLE);
  assign core_stop_o   = (state_q == ST_STOP) || (state_q == ST_OFF);
  assign shdn_no       = (state_q != ST_OFF);
  assign core_reg_en_o = shdn_no & ~reg_dis_i;
  assign busy_o        = (state_q == ST_RST) || (state_q == ST_STOP);

  a_r2_rst_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(start_i));
  a_r3_stop_under_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_stop_o |-> sys_rst_o);
  a_r4_stop_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_no) |-> $past(core_stop_o));
  a_r4_reg_off_with_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_no |-> !core_reg_en_o);
  a_r5_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (sys_rst_o && shdn_no));
  a_r7_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o);
  a_r7_pin_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_no |=> !shdn_no);
endmodule

// File: rtl/bkup_seq_top.sv
module bkup_seq_top #(
  parameter int SYNC_STAGES = 2,
  parameter int STOP_DLY    = 1,
  parameter int OFF_DLY     = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_strobe_i,
  input  logic wr_off_i,
  input  logic reg_dis_i,
  output logic sys_rst_o,
  output logic core_stop_o,
  output logic core_reg_en_o,
  output logic shdn_no,
  output logic busy_o
);
  logic [1:0] raw, synced;
  logic       start;

  assign raw = {reg_dis_i, wr_strobe_i & wr_off_i};

  bkup_sync #(.W(2), .N(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  bkup_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (synced[0]),
    .rise_o(start)
  );

  bkup_fsm #(.STOP_DLY(STOP_DLY), .OFF_DLY(OFF_DLY)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .reg_dis_i    (synced[1]),
    .sys_rst_o    (sys_rst_o),
    .core_stop_o  (core_stop_o),
    .core_reg_en_o(core_reg_en_o),
    .shdn_no      (shdn_no),
    .busy_o       (busy_o)
  );
endmodule

// File: tb/sim_bkup_seq_top.sv
module sim_bkup_seq_top;
  localparam int NS = 2;
  localparam int SD = 2;
  localparam int OD = 3;
  localparam int T_RST  = NS;
  localparam int T_STOP = NS + SD;
  localparam int T_OFF  = NS + SD + OD;
  localparam int LAST   = T_OFF + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, off_bit = 1'b0, dis = 1'b0;
  logic sys_rst, core_stop, reg_en, shdn_n, busy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bkup_seq_top #(.SYNC_STAGES(NS), .STOP_DLY(SD), .OFF_DLY(OD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_strobe_i(strobe), .wr_off_i(off_bit),
    .reg_dis_i(dis), .sys_rst_o(sys_rst), .core_stop_o(core_stop),
    .core_reg_en_o(reg_en), .shdn_no(shdn_n), .busy_o(busy));

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_idle(string tag, logic exp_en);
    check(tag, "sys_rst", sys_rst, 1'b0);
    check(tag, "core_stop", core_stop, 1'b0);
    check(tag, "shdn_n", shdn_n, 1'b1);
    check(tag, "busy", busy, 1'b0);
    check(tag, "reg_en", reg_en, exp_en);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; strobe = 1'b0; off_bit = 1'b0; dis = 1'b0;
    #1;
    check_idle("R9", 1'b1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one full sequence; t counts edges after the first sampling edge
  task automatic run_seq(int width, logic d);
    logic e_rst, e_stop, e_off;
    do_reset();
    dis = d;
    repeat (NS + 1) @(negedge clk);
    check_idle("R8", ~d);
    strobe = 1'b1; off_bit = 1'b1;
    for (int t = 0; t <= LAST; t++) begin
      @(posedge clk); #1;
      e_rst  = (t >= T_RST);
      e_stop = (t >= T_STOP);
      e_off  = (t >= T_OFF);
      check("R2", "sys_rst", sys_rst, e_rst);
      check("R3", "core_stop", core_stop, e_stop);
      check("R4", "shdn_n", shdn_n, ~e_off);
      check("R4", "reg_en", reg_en, ~e_off & ~d);
      check("R5", "busy", busy, e_rst & ~e_off);
      if (t == width - 1) strobe = 1'b0;
      // late writes: during the sequence and after it ended
      if (t == T_STOP || t == T_OFF + 2) strobe = 1'b1;
      if (t == T_STOP + 1 || t == T_OFF + 3) strobe = 1'b0;
    end
    check("R7", "final sys_rst", sys_rst, 1'b1);
    check("R7", "final shdn_n", shdn_n, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    check_idle("R1", 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_idle("R1", 1'b1);

    // R8: mode bit latency in idle
    for (int v = 0; v < 2; v++) begin
      @(negedge clk);
      dis = (v == 0);
      @(posedge clk); #1;
      check("R8", "reg_en before", reg_en, v == 0);
      for (int e = 1; e < NS - 1; e++) begin
        @(posedge clk); #1;
      end
      @(posedge clk); #1;
      check("R8", "reg_en after", reg_en, v != 0);
    end

    // R6: strobe with off bit clear
    @(negedge clk);
    strobe = 1'b1; off_bit = 1'b0;
    @(negedge clk);
    strobe = 1'b0;
    for (int t = 0; t < 10; t++) begin
      @(posedge clk); #1;
      check_idle("R6", 1'b1);
    end

    // R2..R7 sweep over strobe width and mode bit
    for (int d = 0; d < 2; d++)
      for (int w = 1; w <= 3; w++)
        run_seq(w, d[0]);

    // R9: reset from mid-sequence
    do_reset();
    @(negedge clk);
    strobe = 1'b1; off_bit = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (T_STOP) @(posedge clk);
    #1;
    check("R9", "mid core_stop", core_stop, 1'b1);
    do_reset();
    @(posedge clk); #1;
    check_idle("R9", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule